// File: doc/BRIEF.md
# Byte-Lane Read-Strobe Delay Trimmer

This block shifts the read-strobe delay of every byte lane of a memory PHY by one signed step. It works through the PHY's delay register bank. One start pulse carries the step and the number of lanes. The block first asks the voltage/temperature (VT) compensation engine to hold still, and waits for that engine to confirm it has stopped. It then updates each lane in turn by reading its delay register, replacing the 8-bit read-strobe field with a saturated sum, writing the word back and reading it back once. Once all lanes are done it releases the hold and signals completion.

Boot firmware or a training sequencer uses the block after gate training, to nudge every lane by the same margin. Register addresses start at a base address and advance by a fixed stride for each lane. The read port returns data one cycle after the read strobe.

Top module: `dqs_trim_seq`

## Requirements
- R1: After reset, and whenever the block is idle, busy_o, done_o, vt_hold_o, reg_re_o and reg_we_o are all low.
- R2: When the block is idle, a start_i pulse raises vt_hold_o and busy_o on the next cycle. No register read or write is issued until vt_stopped_i has been seen high.
- R3: Lanes are handled in ascending order. Lane i uses address LANE_BASE + i*LANE_STRIDE (0x20 + 8*i by default). Each lane gets a read, then a write two cycles later to the same address, then a read-back of that address in the next cycle, before the next lane starts.
- R4: The written word equals the word read, except for bits 15:8, which hold the new delay.
- R5: step_i is 8-bit two's complement. The new delay is the old delay plus the step, clamped to the range 0 to 255.
- R6: The block handles min(lanes_i, LANE_MAX) lanes (LANE_MAX = 4 by default). Registers of lanes at or above that count are never written. A count of 0 still performs the hold handshake but accesses no register.
- R7: After the last read-back, vt_hold_o drops without waiting for vt_stopped_i to fall. done_o is a single-cycle pulse that comes one cycle after vt_hold_o falls, and busy_o is low in the cycle after done_o.
- R8: A start_i pulse that arrives while busy_o is high is ignored. It changes neither the step nor the lane count of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a trim run when the block is idle |
| step_i | input | 8 | Signed delay step |
| lanes_i | input | 3 | Number of lanes to update |
| vt_hold_o | output | 1 | Request to freeze VT compensation |
| vt_stopped_i | input | 1 | VT compensation confirms it has stopped |
| reg_re_o | output | 1 | Register read strobe |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data, valid one cycle after reg_re_o |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The hardest condition to reach is a second start arriving while a run is in progress. It must arrive with a different step, so that a restart or a captured step would show up as a wrong write. The bench raises this second start a few cycles into a run and makes the VT acknowledgement slow, so the pulse lands during the hold wait. Saturation at both ends is reached by seeding lane fields near 0 and 255 and using steps of -128 and +127. Lane counts of 0 and above LANE_MAX show that the registers beyond the count keep their seeded contents.

// File: rtl/dqs_trim_pkg.sv
package dqs_trim_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_RD, ST_CAP, ST_WR, ST_VFY, ST_VCAP, ST_REL, ST_DONE
  } trim_state_e;
endpackage

// File: rtl/dly_sat_add.sv
module dly_sat_add #(
  parameter int FIELD_W = 8
) (
  input  logic [FIELD_W-1:0] old_i,
  input  logic [FIELD_W-1:0] step_i,
  output logic [FIELD_W-1:0] new_o
);
  localparam int SUM_W = FIELD_W + 2;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {2'b00, old_i} + {{2{step_i[FIELD_W-1]}}, step_i};
    if (sum[SUM_W-1])      new_o = '0;   // below zero
    else if (sum[FIELD_W]) new_o = '1;   // above full scale
    else                   new_o = sum[FIELD_W-1:0];
  end
endmodule

// File: rtl/lane_walk.sv
module lane_walk #(
  parameter int CNT_W       = 3,
  parameter int ADDR_W      = 8,
  parameter int LANE_BASE   = 32,
  parameter int LANE_STRIDE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (adv_i) idx_q <= idx_q + CNT_W'(1);
  end

  assign addr_o = ADDR_W'(LANE_BASE) + ADDR_W'(idx_q) * ADDR_W'(LANE_STRIDE);
  assign last_o = (idx_q + CNT_W'(1)) == cnt_i;
endmodule

// File: rtl/dqs_trim_seq.sv
module dqs_trim_seq
  import dqs_trim_pkg::*;
#(
  parameter int LANE_MAX    = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int LANE_BASE   = 32,
  parameter int LANE_STRIDE = 8,
  parameter int FIELD_LSB   = 8,
  parameter int FIELD_W     = 8,
  localparam int CNT_W      = $clog2(LANE_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FIELD_W-1:0] step_i,
  input  logic [CNT_W-1:0]  lanes_i,
  output logic              vt_hold_o,
  input  logic              vt_stopped_i,
  output logic              reg_re_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [DATA_W-1:0] FMASK = DATA_W'({FIELD_W{1'b1}}) << FIELD_LSB;

  trim_state_e       state_q, state_d;
  logic [FIELD_W-1:0] step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] word_q;
  logic [FIELD_W-1:0] new_fld;
  logic              launch, last_lane;

  assign launch = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        step_q <= step_i;
        cnt_q  <= (lanes_i > CNT_W'(LANE_MAX)) ? CNT_W'(LANE_MAX) : lanes_i;
      end
      if (state_q == ST_CAP) word_q <= reg_rdata_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_HOLD;
      ST_HOLD: if (vt_stopped_i) state_d = (cnt_q == '0) ? ST_REL : ST_RD;
      ST_RD:   state_d = ST_CAP;
      ST_CAP:  state_d = ST_WR;
      ST_WR:   state_d = ST_VFY;
      ST_VFY:  state_d = ST_VCAP;
      ST_VCAP: state_d = last_lane ? ST_REL : ST_RD;
      ST_REL:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  lane_walk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .LANE_BASE(LANE_BASE), .LANE_STRIDE(LANE_STRIDE)
  ) u_walk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch),
    .adv_i ((state_q == ST_VCAP) && !last_lane),
    .cnt_i (cnt_q),
    .addr_o(reg_addr_o),
    .last_o(last_lane)
  );

  dly_sat_add #(.FIELD_W(FIELD_W)) u_sat (
    .old_i (word_q[FIELD_LSB +: FIELD_W]),
    .step_i(step_q),
    .new_o (new_fld)
  );

  always_comb begin
    reg_wdata_o = word_q;
    reg_wdata_o[FIELD_LSB +: FIELD_W] = new_fld;
  end

  assign vt_hold_o = (state_q == ST_HOLD) || (state_q == ST_RD) || (state_q == ST_CAP) ||
                     (state_q == ST_WR) || (state_q == ST_VFY) || (state_q == ST_VCAP);
  assign reg_re_o  = (state_q == ST_RD) || (state_q == ST_VFY);
  assign reg_we_o  = (state_q == ST_WR);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !vt_hold_o && !reg_re_o && !reg_we_o && !done_o);
  // R2
  write_under_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> vt_hold_o && vt_stopped_i);
  // R3
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(reg_re_o, 2) && ($past(reg_addr_o, 2) == reg_addr_o));
  // R3
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_re_o && $stable(reg_addr_o));
  // R4
  preserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ((reg_wdata_o ^ $past(reg_rdata_i)) & ~FMASK) == '0);
  // R7
  hold_drop_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vt_hold_o) |=> done_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: tb/dqs_trim_seq_test.sv
module dqs_trim_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LMAX = 4;
  localparam int BASE = 32;
  localparam int STRIDE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] step = '0;
  logic [2:0] lanes = '0;
  logic vt_hold, vt_stopped, re, we, busy, done;
  logic [7:0] addr;
  logic [31:0] wdata, rdata;

  logic [31:0] mem [0:255];
  logic [39:0] sbq [$];
  int vt_lat = 2, vt_cnt = 0;
  int errors = 0, checks = 0, cycles = 0;
  logic h1 = 1'b0, h2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_trim_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step), .lanes_i(lanes),
    .vt_hold_o(vt_hold), .vt_stopped_i(vt_stopped), .reg_re_o(re), .reg_we_o(we),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !vt_hold) begin
      vt_cnt <= 0;
      vt_stopped <= 1'b0;
    end else if (vt_cnt >= vt_lat) vt_stopped <= 1'b1;
    else vt_cnt <= vt_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on writes, handshake and done timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (re || we) chk(vt_stopped && vt_hold, "R2 access before VT stop", {38'd0, vt_stopped, vt_hold}, 40'd3);
      if (we) begin
        if (sbq.size() == 0) chk(1'b0, "R8 unexpected write", {addr, wdata}, 40'd0);
        else begin
          logic [39:0] e;
          e = sbq.pop_front();
          chk({addr, wdata} == e, "R3/R4/R5 write", {addr, wdata}, e);
        end
      end
      if (done) chk(h2 && !h1 && !vt_hold, "R7 done one cycle after hold drop", {37'd0, h2, h1, vt_hold}, 40'd4);
      h2 <= h1;
      h1 <= vt_hold;
    end
  end

  function automatic logic [31:0] seed(input int i, input int fld);
    return {8'hC3 ^ 8'(i), 8'h5A, 8'(fld), 8'h3C + 8'(i)};
  endfunction

  task automatic run(input int stp, input int nl, input int fld0, input int vlat, input bit dbl, input string tag);
    logic [31:0] fin [LMAX];
    int eff;
    eff = (nl > LMAX) ? LMAX : nl;
    vt_lat = vlat;
    for (int i = 0; i < LMAX; i++) begin
      int f, n;
      f = (fld0 + i * 37) % 256;
      mem[BASE + i*STRIDE] = seed(i, f);
      fin[i] = seed(i, f);
      if (i < eff) begin
        n = f + stp;
        if (n < 0) n = 0;
        if (n > 255) n = 255;
        fin[i][15:8] = 8'(n);
        sbq.push_back({8'(BASE + i*STRIDE), fin[i]});
      end
    end
    @(negedge clk);
    start = 1'b1; step = 8'(stp); lanes = 3'(nl);
    @(negedge clk);
    start = 1'b0;
    chk(busy && vt_hold, {"R2 hold/busy after start ", tag}, {38'd0, busy, vt_hold}, 40'd3);
    if (dbl) begin
      repeat (2) @(negedge clk);
      start = 1'b1; step = 8'd50; lanes = 3'd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done && !vt_hold, {"R7 idle after done ", tag}, {37'd0, busy, done, vt_hold}, 40'd0);
    chk(sbq.size() == 0, {"R6 all lane writes seen ", tag}, 40'(sbq.size()), 40'd0);
    sbq.delete();
    for (int i = 0; i < LMAX; i++)
      chk(mem[BASE + i*STRIDE] == fin[i], {"R6 lane register final ", tag},
          {8'(i), mem[BASE + i*STRIDE]}, {8'(i), fin[i]});
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'(a) * 32'h01010101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !vt_hold && !re && !we, "R1 reset state",
        {35'd0, busy, done, vt_hold, re, we}, 40'd0);
    run(4, 4, 128, 2, 1'b0, "plus4");
    run(-4, 2, 2, 1, 1'b0, "minus4 low clamp");
    run(100, 3, 200, 3, 1'b0, "high clamp");
    run(-128, 4, 100, 0, 1'b0, "min step");
    run(127, 4, 255, 2, 1'b0, "max step");
    run(9, 0, 10, 4, 1'b0, "zero lanes");
    run(-1, 7, 0, 2, 1'b0, "count above max");
    run(-20, 3, 60, 6, 1'b1, "R8 start while busy");
    chk(mem[BASE - STRIDE] == 32'(BASE - STRIDE) * 32'h01010101, "R6 below base untouched",
        {8'd0, mem[BASE - STRIDE]}, {8'd0, 32'(BASE - STRIDE) * 32'h01010101});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule